// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block stores, for every interrupt line, an 8-bit mask of the CPUs that the interrupt may be delivered to. Software reaches the masks through a simple memory-mapped request port. Each interrupt owns one byte, and the interrupt number equals the byte offset from the start of the bank, so one 32-bit word holds four neighbouring interrupts. Byte-wide and word-wide reads and writes are both accepted.

Every stored mask also drives a 3-bit resolved target index, which is the position of its lowest set bit. A downstream forwarding stage consumes these indices directly. A written byte is clipped to the CPUs currently online, given as a count. The first `NUM_PRIV` entries belong to private interrupts. They keep a fixed value set by a parameter, and writes to them are ignored.

A small response state machine has two named states. `ST_IDLE` means no read data is presented. `ST_RESP` means read data is valid for this cycle. Its transitions are as follows. *issue-read* goes from either state into `ST_RESP` whenever a read request is accepted. *drain* goes from `ST_RESP` back to `ST_IDLE` when the cycle holds no read request. *stay-idle* keeps `ST_IDLE` on a write or on no request.

Top module: `tgt_route_bank`

## Requirements
- R1: After reset, every shared entry reads 0x00, every private entry reads the `PRIV_RESET` value, and `rsp_valid` is low.
- R2: A byte write (`req_word`=0) takes its data from `req_wdata[7:0]` and updates only the entry whose ID equals `req_addr`. Its neighbours keep their values.
- R3: A word write (`req_word`=1) ignores `req_addr[1:0]`. It writes byte lane i (`req_wdata[8i+7:8i]`) to entry ID (`req_addr` with bits 1:0 cleared) + i, handling each lane on its own.
- R4: Each written byte is ANDed with a mask whose low N bits are set, where N is `online_cpus`. N=0 stores zero, and N of 8 or more stores the byte unchanged.
- R5: Writes that address entries with ID below `NUM_PRIV` leave those entries unchanged.
- R6: A word read returns entries base..base+3 in ascending byte lanes. A byte read returns the addressed entry in `rsp_rdata[7:0]`, with bits 31:8 set to zero.
- R7: `rsp_valid` is high exactly in the cycle after an accepted read, and it carries that read's data. Back-to-back reads give back-to-back responses. A write never raises `rsp_valid`.
- R8: `tgt_index[3e+2:3e]` holds the bit position of the lowest set bit of entry e's mask, or 0 when the mask is empty. It follows a write in the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| req_addr | input | $clog2(NUM_IRQ) | Byte offset, which equals the interrupt ID |
| req_wdata | input | 32 | Write data |
| online_cpus | input | 4 | Number of online CPUs |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tgt_index | output | 3*NUM_IRQ | Resolved lowest-set-bit target per interrupt |

## Verification
The assertions assume that `req_valid`, `req_we` and `req_word` are never unknown while out of reset. They also take `online_cpus` as sampled in the write cycle as the only clipping mask that applies. The bench drives every input on the falling edge, holds `online_cpus` steady across each write, and keeps addresses inside the bank. Each read places its expected word in a queue built from a byte-level model of the requirements. A monitor then compares that entry with each response as it arrives.

// File: rtl/tgt_bank_pkg.sv
package tgt_bank_pkg;

    localparam int TGT_W  = 8;
    localparam int IDX_W  = 3;
    localparam int LANES  = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    function automatic logic [TGT_W-1:0] online_mask(input logic [3:0] n);
        logic [TGT_W:0] t;
        if (n >= 4'(TGT_W)) begin
            return {TGT_W{1'b1}};
        end
        t = (9'd1 << n) - 9'd1;
        return t[TGT_W-1:0];
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(input logic [TGT_W-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = TGT_W - 1; i >= 0; i--) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tgt_lane_dec.sv
module tgt_lane_dec
    import tgt_bank_pkg::*;
#(
    parameter int ID_W = 7
) (
    input  logic                        req_valid,
    input  logic                        req_we,
    input  logic                        req_word,
    input  logic [ID_W-1:0]             req_addr,
    input  logic [31:0]                 req_wdata,
    input  logic [3:0]                  online_cpus,
    output logic                        wr_go,
    output logic                        rd_go,
    output logic [ID_W-3:0]             group_sel,
    output logic [1:0]                  lane_sel,
    output logic [LANES-1:0]            lane_en,
    output logic [LANES-1:0][TGT_W-1:0] lane_data
);

    logic [TGT_W-1:0] clip;

    always_comb begin
        wr_go     = req_valid && req_we;
        rd_go     = req_valid && !req_we;
        group_sel = req_addr[ID_W-1:2];
        lane_sel  = req_addr[1:0];
        clip      = online_mask(online_cpus);
        lane_en   = req_word ? {LANES{1'b1}} : (LANES'(1) << req_addr[1:0]);
        for (int i = 0; i < LANES; i++) begin
            lane_data[i] = (req_word ? req_wdata[8*i +: 8] : req_wdata[7:0]) & clip;
        end
    end

endmodule

// File: rtl/tgt_entry.sv
module tgt_entry
    import tgt_bank_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TGT_W-1:0] wr_data,
    input  logic [3:0]       online_cpus,
    output logic [TGT_W-1:0] mask_q,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= RST_VAL;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

    always_comb idx = lowest_set(mask_q);

    // R4: stored mask has no bit above the online count sampled at the write
    a_r4_clip_online: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mask_q & ~online_mask($past(online_cpus))) == '0));

    // R2: an entry without a write enable keeps its value
    a_r2_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    // R8: index points at a set bit with nothing set below it
    a_r8_lowest_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |-> (mask_q[idx] && ((mask_q & ((8'd1 << idx) - 8'd1)) == '0)));

    // R8: empty mask resolves to index zero
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (idx == '0));

endmodule

// File: rtl/tgt_read_mux.sv
module tgt_read_mux
    import tgt_bank_pkg::*;
#(
    parameter int NUM_IRQ = 128,
    parameter int ID_W    = 7
) (
    input  logic [NUM_IRQ*TGT_W-1:0] masks_flat,
    input  logic [ID_W-3:0]          group_sel,
    input  logic [1:0]               lane_sel,
    input  logic                     req_word,
    output logic [31:0]              rd_word
);

    logic [31:0]      grp;
    logic [TGT_W-1:0] one;

    always_comb begin
        grp     = masks_flat[{group_sel, 5'b0} +: 32];
        one     = grp[{lane_sel, 3'b0} +: 8];
        rd_word = req_word ? grp : {24'h0, one};
    end

endmodule

// File: rtl/tgt_route_bank.sv
module tgt_route_bank
    import tgt_bank_pkg::*;
#(
    parameter int         NUM_IRQ    = 128,
    parameter int         NUM_PRIV   = 32,
    parameter logic [7:0] PRIV_RESET = 8'h01,
    localparam int        ID_W       = $clog2(NUM_IRQ),
    localparam int        GRP_W      = ID_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_we,
    input  logic                     req_word,
    input  logic [ID_W-1:0]          req_addr,
    input  logic [31:0]              req_wdata,
    input  logic [3:0]               online_cpus,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic [NUM_IRQ*IDX_W-1:0] tgt_index
);

    logic                        wr_go;
    logic                        rd_go;
    logic [GRP_W-1:0]            group_sel;
    logic [1:0]                  lane_sel;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][TGT_W-1:0] lane_data;
    logic [NUM_IRQ*TGT_W-1:0]    masks_flat;
    logic [31:0]                 rd_word;
    rsp_state_e                  state_q, state_d;
    logic [31:0]                 rdata_q;

    tgt_lane_dec #(.ID_W(ID_W)) u_dec (
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_word    (req_word),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .online_cpus (online_cpus),
        .wr_go       (wr_go),
        .rd_go       (rd_go),
        .group_sel   (group_sel),
        .lane_sel    (lane_sel),
        .lane_en     (lane_en),
        .lane_data   (lane_data)
    );

    for (genvar e = 0; e < NUM_IRQ; e++) begin : g_ent
        logic we_e;
        if (e < NUM_PRIV) begin : g_priv
            assign we_e = 1'b0;
        end else begin : g_shared
            assign we_e = wr_go && lane_en[e % LANES] && (group_sel == GRP_W'(e / LANES));
        end
        tgt_entry #(.RST_VAL((e < NUM_PRIV) ? PRIV_RESET : 8'h00)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (we_e),
            .wr_data     (lane_data[e % LANES]),
            .online_cpus (online_cpus),
            .mask_q      (masks_flat[e*TGT_W +: TGT_W]),
            .idx         (tgt_index[e*IDX_W +: IDX_W])
        );
    end

    tgt_read_mux #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_rmux (
        .masks_flat (masks_flat),
        .group_sel  (group_sel),
        .lane_sel   (lane_sel),
        .req_word   (req_word),
        .rd_word    (rd_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_go) rdata_q <= rd_word;
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;

    // R7: a read is answered in the next cycle
    a_r7_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> rsp_valid);

    // R7: no response without a read in the previous cycle
    a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> !rsp_valid);

    // R6: byte read clears upper lanes
    a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && !req_word) |=> (rsp_rdata[31:8] == 24'h0));

    // R5: private entries do not move on a write aimed at them
    a_r5_priv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && (int'(req_addr) < NUM_PRIV))
        |=> $stable(masks_flat[NUM_PRIV*TGT_W-1:0]));

endmodule

// File: tb/tb_tgt_route_bank.sv
module tb_tgt_route_bank;

    localparam int         N_IRQ  = 128;
    localparam int         N_PRIV = 32;
    localparam logic [7:0] PRST   = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_we, req_word;
    logic [6:0]  req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  online_cpus;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [N_IRQ*3-1:0] tgt_index;

    int checks = 0;
    int errors = 0;
    logic [7:0]  model [N_IRQ];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tgt_route_bank #(.NUM_IRQ(N_IRQ), .NUM_PRIV(N_PRIV), .PRIV_RESET(PRST)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .online_cpus(online_cpus), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tgt_index(tgt_index)
    );

    function automatic logic [7:0] clipm(input int n);
        if (n >= 8) return 8'hFF;
        return 8'((1 << n) - 1);
    endfunction

    function automatic logic [2:0] ffs_ref(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_we = 1'b0; req_word = 1'b0;
    endtask

    // driver: write, model update, no response expected
    task automatic wr(input bit word, input int addr, input logic [31:0] d, input string req);
        req_valid = 1'b1; req_we = 1'b1; req_word = word;
        req_addr = 7'(addr); req_wdata = d;
        if (word) begin
            for (int i = 0; i < 4; i++) begin
                int id = (addr & ~3) + i;
                if (id >= N_PRIV) model[id] = d[8*i +: 8] & clipm(int'(online_cpus));
            end
        end else if (addr >= N_PRIV) begin
            model[addr] = d[7:0] & clipm(int'(online_cpus));
        end
        @(negedge clk);
        idle();
        check(rsp_valid == 1'b0, {req, "/R7 no rsp on write"}, 32'(rsp_valid), 32'h0);
    endtask

    // driver: read, expected value pushed to scoreboard
    task automatic rd(input bit word, input int addr, input string req, input bit keep = 0);
        logic [31:0] e;
        req_valid = 1'b1; req_we = 1'b0; req_word = word; req_addr = 7'(addr);
        if (word) begin
            int b = addr & ~3;
            e = {model[b+3], model[b+2], model[b+1], model[b]};
        end else begin
            e = {24'h0, model[addr]};
        end
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        if (!keep) idle();
    endtask

    task automatic chk_idx(input int id, input string req);
        logic [2:0] exp;
        exp = ffs_ref(model[id]);
        check(tgt_index[id*3 +: 3] == exp, {req, "/R8 index"}, 32'(tgt_index[id*3 +: 3]), 32'(exp));
    endtask

    // monitor: pops and compares responses
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected rsp", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata == e, t, rsp_rdata, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N_IRQ; i++) model[i] = (i < N_PRIV) ? PRST : 8'h00;
        rst_n = 1'b0; online_cpus = 4'd8; req_addr = '0; req_wdata = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
        rd(1, 0, "R1 priv reset word");
        rd(1, 32, "R1 shared reset word");
        rd(1, 124, "R1 top reset word");
        chk_idx(0, "R1");
        chk_idx(33, "R1");
        // R2: byte write
        wr(0, 40, 32'hFFFF_FFA0, "R2");
        rd(0, 40, "R2 byte readback");
        rd(1, 40, "R2 neighbours intact");
        chk_idx(40, "R2");
        // R3: word write and misaligned word address
        wr(1, 44, 32'h8010_0C03, "R3");
        rd(1, 44, "R3 word readback");
        for (int i = 44; i < 48; i++) chk_idx(i, "R3");
        wr(1, 49, 32'h1122_4488, "R3");
        rd(1, 48, "R3 low addr bits ignored");
        // R6: byte read of a lane
        rd(0, 46, "R6 byte lane 2");
        rd(0, 47, "R6 byte lane 3");
        // R4: clipping
        online_cpus = 4'd3;
        wr(1, 52, 32'hFFF0_0605, "R4");
        rd(1, 52, "R4 clipped to 3 cpus");
        for (int i = 52; i < 56; i++) chk_idx(i, "R4");
        online_cpus = 4'd0;
        wr(0, 56, 32'h0000_00FF, "R4");
        online_cpus = 4'd12;
        wr(0, 57, 32'h0000_00FF, "R4");
        online_cpus = 4'd1;
        wr(0, 58, 32'h0000_00FE, "R4");
        rd(1, 56, "R4 zero/full/one cpu");
        online_cpus = 4'd8;
        // R5: private entries ignore writes
        wr(1, 0, 32'hFFFF_FFFF, "R5");
        wr(0, 31, 32'h0000_0080, "R5");
        rd(1, 0, "R5 priv word unchanged");
        rd(0, 31, "R5 priv byte unchanged");
        chk_idx(0, "R5");
        chk_idx(31, "R5");
        // R8: highest entry
        wr(0, 127, 32'h0000_0040, "R8");
        chk_idx(127, "R8");
        wr(0, 126, 32'h0000_0000, "R8");
        chk_idx(126, "R8");
        rd(1, 124, "R8 top word");
        // R7: back-to-back reads
        rd(1, 44, "R7 b2b a", 1);
        rd(0, 45, "R7 b2b b", 1);
        rd(1, 52, "R7 b2b c");
        // R2/R3: overwrite then read the next cycle
        wr(1, 100, 32'h0102_0408, "R3");
        rd(1, 100, "R3 read after write");
        for (int i = 100; i < 104; i++) chk_idx(i, "R3");
        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R7 all reads answered", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule